// File: doc/BRIEF.md
# Minimum-Delta Coordinate Filter

This block picks one steady X coordinate and one steady Y coordinate out of a burst of noisy 12-bit converter samples. Two show-ahead FIFOs, one for each axis, present their head words. The block pops one X word and one Y word together in each cycle of a burst. For each axis it keeps the previous sample and the smallest jump seen so far. The sample with the smallest jump from the sample just before it becomes that axis's result.

A burst starts with a one-cycle `start` pulse that carries the FIFO entry count. The last entry of each FIFO is kept for a later stage, so the block consumes one pair fewer than the count. When the burst ends, the chosen coordinates appear on `outX` and `outY` with a one-cycle `outValid` strobe. They stay there until the next burst is accepted. Nothing is averaged, and the two axes choose their samples independently.

Top module: `minDeltaFilter`

## Requirements
- R1: Only bits [11:0] of each FIFO word are used as the sample. All higher word bits have no effect on the results.
- R2: When idle, a `start` pulse is accepted. The number of pairs consumed is `entryCount - 1`, or zero when `entryCount` is 0 or 1. `pop` is high for exactly that many consecutive cycles, starting the cycle after the accepting edge.
- R3: At the accepting edge, each axis sets its previous-value and best-difference registers to 8191 (13 bits, all ones) and its chosen coordinate to 0. Each sample's difference is the 13-bit absolute value of sample minus previous value.
- R4: When a difference is strictly smaller than the best difference, both the best difference and the chosen coordinate take the new values. On a tie the earlier choice is kept.
- R5: The previous value takes every consumed sample, whether or not that sample was chosen.
- R6: X and Y consume one sample each per `pop` cycle and choose independently. A pattern on one axis does not change the other axis's result.
- R7: `outValid` is high for exactly one cycle: the cycle after the last `pop` cycle, or the cycle after the accepting edge when no pairs are consumed. `outX` and `outY` hold their values until the next accepted `start`.
- R8: A burst with zero pairs gives `outX = outY = 0` with `outValid`.
- R9: A `start` while `busy` is high is ignored. It does not change the pop count or the results of the burst in progress.
- R10: After reset, `busy`, `pop` and `outValid` are low and `outX = outY = 0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a burst (accepted only when idle) |
| entryCount | input | CNT_W (8) | FIFO entry count for the burst |
| xWord | input | WORD_W (32) | Head word of the X FIFO |
| yWord | input | WORD_W (32) | Head word of the Y FIFO |
| pop | output | 1 | Consume the head word of both FIFOs this cycle |
| busy | output | 1 | A burst is in progress |
| outValid | output | 1 | One-cycle strobe: results are ready |
| outX | output | SAMP_W (12) | Chosen X coordinate |
| outY | output | SAMP_W (12) | Chosen Y coordinate |

## Verification
The assertions watch the control contract on every cycle:
- `pop` occurs only during a burst.
- `outValid` is a single-cycle pulse that never coincides with `pop`.
- An accepted `start` always raises `busy`.
- The results stay still while the block is idle.
- The number of pops in a burst matches the count that was accepted.

Which sample each axis chooses, including ties, the all-ones first comparison, masking of the upper word bits and the independence of the axes, can only be shown by the bench's scenarios. The bench compares those results against an arithmetic model over a sweep of burst lengths and crafted patterns.

// File: rtl/minDeltaPkg.sv
package minDeltaPkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic init;  // clear per-axis state at burst start
    logic step;  // consume one sample pair
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_DONE = 2'd2
  } ctlState_t;
endpackage

// File: rtl/minDeltaCtl.sv
module minDeltaCtl
  import minDeltaPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] entryCount,
  output ctlStrobe_t       ctl,
  output logic             pop,
  output logic             busy,
  output logic             outValid
);
  ctlState_t        state;
  logic [CNT_W-1:0] remaining;
  logic [CNT_W-1:0] pairs;

  // last FIFO entry is reserved for a later stage
  assign pairs = (entryCount == '0) ? '0 : entryCount - 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      remaining <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (start) begin
            remaining <= pairs;
            state     <= (pairs == '0) ? S_DONE : S_RUN;
          end
        end
        S_RUN: begin
          remaining <= remaining - 1'b1;
          if (remaining == {{(CNT_W-1){1'b0}}, 1'b1}) state <= S_DONE;
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.init = (state == S_IDLE) && start;
    ctl.step = (state == S_RUN);
  end

  assign pop      = (state == S_RUN);
  assign busy     = (state != S_IDLE);
  assign outValid = (state == S_DONE);
endmodule

// File: rtl/minDeltaPath.sv
module minDeltaPath
  import minDeltaPkg::*;
#(
  parameter int WORD_W = 32,
  parameter int SAMP_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [WORD_W-1:0] xWord,
  input  logic [WORD_W-1:0] yWord,
  output logic [SAMP_W-1:0] outX,
  output logic [SAMP_W-1:0] outY
);
  localparam int DIFF_W = SAMP_W + 1;
  localparam int AXES   = 2;

  logic [AXES-1:0][WORD_W-1:0] words;
  logic [AXES-1:0][SAMP_W-1:0] chosenAll;

  assign words[0] = xWord;
  assign words[1] = yWord;

  for (genvar a = 0; a < AXES; a++) begin : gAxis
    logic [SAMP_W-1:0] sample;
    logic [DIFF_W-1:0] sampleExt;
    logic [DIFF_W-1:0] prevVal;
    logic [DIFF_W-1:0] bestDiff;
    logic [DIFF_W-1:0] curDiff;
    logic [SAMP_W-1:0] chosen;
    logic              better;

    assign sample    = words[a][SAMP_W-1:0];
    assign sampleExt = {1'b0, sample};

    always_comb begin
      if (sampleExt >= prevVal) curDiff = sampleExt - prevVal;
      else                      curDiff = prevVal - sampleExt;
    end

    assign better = (curDiff < bestDiff);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        prevVal  <= '1;
        bestDiff <= '1;
        chosen   <= '0;
      end else if (ctl.init) begin
        prevVal  <= '1;
        bestDiff <= '1;
        chosen   <= '0;
      end else if (ctl.step) begin
        prevVal <= sampleExt;
        if (better) begin
          bestDiff <= curDiff;
          chosen   <= sample;
        end
      end
    end

    assign chosenAll[a] = chosen;
  end

  assign outX = chosenAll[0];
  assign outY = chosenAll[1];
endmodule

// File: rtl/minDeltaFilter.sv
module minDeltaFilter
  import minDeltaPkg::*;
#(
  parameter int WORD_W = 32,
  parameter int SAMP_W = 12,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CNT_W-1:0]  entryCount,
  input  logic [WORD_W-1:0] xWord,
  input  logic [WORD_W-1:0] yWord,
  output logic              pop,
  output logic              busy,
  output logic              outValid,
  output logic [SAMP_W-1:0] outX,
  output logic [SAMP_W-1:0] outY
);
  ctlStrobe_t ctl;

  minDeltaCtl #(.CNT_W(CNT_W)) uCtl (
    .clk(clk), .rstN(rstN), .start(start), .entryCount(entryCount),
    .ctl(ctl), .pop(pop), .busy(busy), .outValid(outValid)
  );

  minDeltaPath #(.WORD_W(WORD_W), .SAMP_W(SAMP_W)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .xWord(xWord), .yWord(yWord),
    .outX(outX), .outY(outY)
  );
endmodule

// File: rtl/minDeltaChk.sv
module minDeltaChk #(
  parameter int SAMP_W = 12,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [CNT_W-1:0]  entryCount,
  input logic              pop,
  input logic              busy,
  input logic              outValid,
  input logic [SAMP_W-1:0] outX,
  input logic [SAMP_W-1:0] outY
);
  logic [CNT_W-1:0] expPairs;
  logic [CNT_W-1:0] popCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      expPairs <= '0;
      popCnt   <= '0;
    end else if (start && !busy) begin
      expPairs <= (entryCount == '0) ? '0 : entryCount - 1'b1;
      popCnt   <= '0;
    end else if (pop) begin
      popCnt <= popCnt + 1'b1;
    end
  end

  p_pop_in_burst_r2: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> busy);

  p_pop_count_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (popCnt == expPairs));

  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  p_valid_not_pop_r7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !pop);

  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(outX) && $stable(outY)));

  p_accept_r9: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
endmodule

bind minDeltaFilter minDeltaChk #(.SAMP_W(SAMP_W), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .entryCount(entryCount),
  .pop(pop), .busy(busy), .outValid(outValid), .outX(outX), .outY(outY)
);

// File: tb/minDeltaFilter_test.sv
module minDeltaFilter_test;
  localparam int WORD_W = 32;
  localparam int SAMP_W = 12;
  localparam int CNT_W  = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [CNT_W-1:0]  entryCount = '0;
  logic [WORD_W-1:0] xWord, yWord;
  logic              pop, busy, outValid;
  logic [SAMP_W-1:0] outX, outY;

  logic [WORD_W-1:0] xMem [0:63];
  logic [WORD_W-1:0] yMem [0:63];
  logic [5:0]        idx = '0;
  logic              rewind = 1'b0;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int unsigned seed = 32'h1234_5678;

  minDeltaFilter #(.WORD_W(WORD_W), .SAMP_W(SAMP_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .start(start), .entryCount(entryCount),
    .xWord(xWord), .yWord(yWord), .pop(pop), .busy(busy),
    .outValid(outValid), .outX(outX), .outY(outY)
  );

  always #5 clk = ~clk;

  // show-ahead FIFO model
  assign xWord = xMem[idx];
  assign yWord = yMem[idx];
  always @(posedge clk) begin
    if (rewind) idx <= '0;
    else if (pop) idx <= idx + 1'b1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual cyc=%0d expected <150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int unsigned nextRand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  // Arithmetic model of the choice on one axis
  function automatic int modelPick(input bit yAxis, input int pairs);
    int prev = 8191, best = 8191, ch = 0;
    for (int i = 0; i < pairs; i++) begin
      int s, d;
      s = yAxis ? int'(yMem[i] & 32'hFFF) : int'(xMem[i] & 32'hFFF);
      d = (s >= prev) ? s - prev : prev - s;
      if (d < best) begin best = d; ch = s; end
      prev = s;
    end
    return ch;
  endfunction

  // Run one burst; optionally inject a start while busy
  task automatic runBurst(input int count, input bit midStart, input string tag);
    int pairs, lat, pops, ex, ey;
    pairs = (count == 0) ? 0 : count - 1;
    ex = modelPick(1'b0, pairs);
    ey = modelPick(1'b1, pairs);
    @(negedge clk);
    start = 1'b1; rewind = 1'b1; entryCount = CNT_W'(count);
    @(negedge clk);
    start = 1'b0; rewind = 1'b0;
    lat = 1; pops = 0;
    while (!outValid && lat < 200) begin
      if (pop) pops++;
      if (midStart && lat == 2) begin start = 1'b1; entryCount = 8'd3; end
      else start = 1'b0;
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    check(lat == pairs + 1, {tag, " R7 latency"}, lat, pairs + 1);
    check(pops == pairs, {tag, " R2 pop count"}, pops, pairs);
    check(int'(outX) == ex, {tag, " R4 outX"}, int'(outX), ex);
    check(int'(outY) == ey, {tag, " R6 outY"}, int'(outY), ey);
    @(negedge clk);
    check(!outValid, {tag, " R7 single pulse"}, int'(outValid), 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin xMem[i] = '0; yMem[i] = '0; end
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!busy && !pop && !outValid, "R10 reset control", int'({busy, pop, outValid}), 0);
    check(outX == 0 && outY == 0, "R10 reset coords", int'(outX), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R8 zero pairs, from count 0 and count 1
    for (int i = 0; i < 4; i++) begin xMem[i] = 32'h1_0345; yMem[i] = 32'h777; end
    runBurst(0, 1'b0, "R8 count0");
    check(outX == 0 && outY == 0, "R8 zero pairs", int'(outX), 0);
    runBurst(1, 1'b0, "R8 count1");
    check(outX == 0 && outY == 0, "R8 zero pairs c1", int'(outX), 0);

    // R3 first sample against 8191; sample 0 ties and is not chosen
    xMem[0] = 32'h0; yMem[0] = 32'h0000_0FFF;
    runBurst(2, 1'b0, "R3 first");
    check(outX == 0, "R3 zero sample not chosen", int'(outX), 0);
    check(outY == 12'hFFF, "R3 first sample chosen", int'(outY), 4095);

    // R4 tie keeps earlier: 100,110,120 -> 110
    xMem[0] = 100; xMem[1] = 110; xMem[2] = 120;
    // R5 prev always updates: 100,500,505 -> 505
    yMem[0] = 100; yMem[1] = 500; yMem[2] = 505;
    runBurst(4, 1'b0, "R4R5");
    check(outX == 110, "R4 tie keeps earlier", int'(outX), 110);
    check(outY == 505, "R5 prev follows every sample", int'(outY), 505);

    // R1 high bits ignored: same low bits, garbage above
    xMem[0] = 32'hABCD_0100; xMem[1] = 32'h5555_5800; xMem[2] = 32'hFFFF_F805;
    yMem[0] = 32'h0000_0100; yMem[1] = 32'h0000_0800; yMem[2] = 32'h0000_0805;
    runBurst(4, 1'b0, "R1");
    check(outX == outY && outY == 12'h805, "R1 low 12 bits only", int'(outX), 12'h805);

    // R7 hold after valid
    repeat (5) @(negedge clk);
    check(outX == 12'h805 && !outValid, "R7 hold while idle", int'(outX), 12'h805);

    // R9 start while busy ignored
    for (int i = 0; i < 20; i++) begin xMem[i] = nextRand(); yMem[i] = nextRand(); end
    runBurst(12, 1'b1, "R9 midstart");

    // Sweep lengths with random full-width words (R1, R2, R6)
    for (int n = 0; n <= 40; n++) begin
      for (int i = 0; i < 64; i++) begin
        xMem[i] = nextRand();
        yMem[i] = (n % 2 == 0) ? nextRand() : ((nextRand() & 32'hFFFF_F00F) | 32'h0000_0800);
      end
      runBurst(n, 1'b0, "sweep");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule